// File: doc/BRIEF.md
# DMA Channel Count and Autoload Controller

This block keeps the per-channel transfer parameters of a four-channel DMA engine. Each channel has a start address, a transfer count and a transfer type. The CPU loads these fields one at a time and writes a mode word. The mode word carries the channel enable bits, a stop-on-terminal-count option and an autoload option. The bus sequencer pulses a transfer strobe, together with a channel number, once per bus transfer. On each accepted strobe the selected channel's address steps up and its count steps down. On the last transfer of a block the controller raises a one-cycle terminal-count pulse.

In autoload mode, channel 3 acts as a reload register set for channel 2. Every parameter write to channel 2 is also written into channel 3. When channel 2 finishes its block, an update cycle copies channel 3 back into channel 2 so that the next block starts with no software action. During the reload the update flag is high. Software polls this flag so that it does not rewrite channel 3 before the copy has been made. Channel 3 can still carry its own transfers in this mode, and those transfers change the values that are reloaded.

The address and transfer type shown on the outputs belong to the channel selected by the sequencer's channel number.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset all enable bits are 0 and the update flag and terminal-count pulse are low. Every channel has address 0, count 0 and type verify.
- R2: An accepted transfer raises the channel's address by 1 (wrapping at 16 bits) and lowers its 14-bit count by 1. A transfer made while the count is 0 is the final one and raises `tc_o` for exactly the cycle after it. `addr_o` and `type_o` always show the channel named by `xfer_ch_i`.
- R3: When the stop mode bit is 1, terminal count clears that channel's enable bit. The exception is channel 2 while autoload is on, whose enable bit stays set.
- R4: When the stop mode bit is 0, terminal count leaves every enable bit unchanged.
- R5: A transfer strobe on a disabled channel changes neither its address nor its count and gives no terminal-count pulse. A channel disabled by terminal count transfers again only after a mode write sets its enable bit.
- R6: A parameter write selects its field with `wr_field_i`: 0 for the address, 1 for the count, 2 for the type. Type codes are 0 verify, 1 write (I/O to memory) and 2 read (memory to I/O). A type write of code 3 is ignored and the old type is kept.
- R7: With autoload on, every write to channel 2 is also written to channel 3. A write to channel 3 never changes channel 2.
- R8: With autoload on, channel 2's terminal count raises `update_o` in the next cycle. At the end of that cycle channel 3's address, count and type are copied into channel 2. `update_o` falls one cycle after the copy. A channel 2 strobe during the copy cycle is ignored.
- R9: With autoload on, transfers on channel 3 advance channel 3, so the next reload into channel 2 takes the advanced address and count.
- R10: With autoload off, channel 2 writes do not reach channel 3, and channel 2's terminal count does not raise `update_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Parameter write strobe |
| wr_ch_i | input | 2 | Channel addressed by the write |
| wr_field_i | input | 2 | Field select: 0 address, 1 count, 2 type |
| wr_data_i | input | 16 | Write data |
| mode_wr_i | input | 1 | Mode word write strobe |
| mode_en_i | input | 4 | New channel enable bits |
| mode_tcstop_i | input | 1 | New stop-on-terminal-count option |
| mode_auto_i | input | 1 | New autoload option |
| xfer_i | input | 1 | Transfer strobe from the bus sequencer |
| xfer_ch_i | input | 2 | Channel of the transfer; also selects the outputs |
| addr_o | output | 16 | Current address of the selected channel |
| type_o | output | 2 | Transfer type of the selected channel |
| tc_o | output | 1 | Terminal-count pulse |
| en_o | output | 4 | Channel enable bits |
| update_o | output | 1 | Autoload update flag |

## Verification
The bench runs a channel through its final transfer with the stop option on. It then checks that the channel goes quiet until it is re-enabled. A design that decremented before testing for zero would pulse one transfer early, and one that ignored the enable bits would keep counting. The autoload checks send a strobe into the copy cycle and then compare channel 2 against channel 3's values. A design that let that strobe through would show an address one too high. The bench also checks channel 2's enable bit across its terminal count under the stop option, which catches a design that disables channel 2 despite autoload. Last, it checks that a reserved type code leaves the stored type unchanged.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 14;
  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    XT_VERIFY = 2'd0,
    XT_WRITE  = 2'd1,
    XT_READ   = 2'd2,
    XT_RSVD   = 2'd3
  } xfer_type_e;

  typedef enum logic [1:0] {
    FLD_ADDR  = 2'd0,
    FLD_COUNT = 2'd1,
    FLD_TYPE  = 2'd2
  } field_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [CNT_W-1:0]  cnt;
    xfer_type_e        kind;
  } chan_par_t;
endpackage

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
  import dma_chan_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_addr_i,
  input  logic              ld_cnt_i,
  input  logic              ld_type_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              reload_i,
  input  chan_par_t         reload_val_i,
  input  logic              step_i,
  output chan_par_t         par_o
);
  chan_par_t par_q;

  // reload overrides cpu loads, cpu loads override stepping
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_q <= '{addr: '0, cnt: '0, kind: XT_VERIFY};
    end else if (reload_i) begin
      par_q <= reload_val_i;
    end else begin
      if (ld_addr_i)   par_q.addr <= wdata_i[ADDR_W-1:0];
      else if (step_i) par_q.addr <= par_q.addr + 1'b1;
      if (ld_cnt_i)    par_q.cnt  <= wdata_i[CNT_W-1:0];
      else if (step_i) par_q.cnt  <= par_q.cnt - 1'b1;
      if (ld_type_i)   par_q.kind <= xfer_type_e'(wdata_i[1:0]);
    end
  end

  assign par_o = par_q;
endmodule

// File: rtl/dma_mode_ctrl.sv
module dma_mode_ctrl #(
  parameter int NUM_CH = 4,
  parameter int SRC_CH = 2,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_wr_i,
  input  logic [NUM_CH-1:0] mode_en_i,
  input  logic              mode_tcstop_i,
  input  logic              mode_auto_i,
  input  logic              tc_hit_i,
  input  logic [CH_W-1:0]   tc_ch_i,
  output logic [NUM_CH-1:0] en_o,
  output logic              tcstop_o,
  output logic              auto_o
);
  logic [NUM_CH-1:0] en_q, en_d;
  logic              tcstop_q, auto_q;
  logic              stop_hit;

  assign stop_hit = tc_hit_i && tcstop_q && !(auto_q && tc_ch_i == CH_W'(SRC_CH));

  always_comb begin
    en_d = en_q;
    if (stop_hit)  en_d[tc_ch_i] = 1'b0;
    if (mode_wr_i) en_d = mode_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= '0;
      tcstop_q <= 1'b0;
      auto_q   <= 1'b0;
    end else begin
      en_q <= en_d;
      if (mode_wr_i) begin
        tcstop_q <= mode_tcstop_i;
        auto_q   <= mode_auto_i;
      end
    end
  end

  assign en_o     = en_q;
  assign tcstop_o = tcstop_q;
  assign auto_o   = auto_q;
endmodule

// File: rtl/dma_autoload_seq.sv
module dma_autoload_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic copy_o,
  output logic busy_o
);
  typedef enum logic [1:0] {AL_IDLE, AL_COPY, AL_HOLD} al_state_e;
  al_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      AL_IDLE: if (start_i) state_d = AL_COPY;
      AL_COPY: state_d = AL_HOLD;
      AL_HOLD: state_d = start_i ? AL_COPY : AL_IDLE;
      default: state_d = AL_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= AL_IDLE;
    else         state_q <= state_d;
  end

  assign copy_o = (state_q == AL_COPY);
  assign busy_o = (state_q != AL_IDLE);
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SRC_CH = 2,
  parameter int SHD_CH = 3,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CH_W-1:0]   wr_ch_i,
  input  logic [1:0]        wr_field_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              mode_wr_i,
  input  logic [NUM_CH-1:0] mode_en_i,
  input  logic              mode_tcstop_i,
  input  logic              mode_auto_i,
  input  logic              xfer_i,
  input  logic [CH_W-1:0]   xfer_ch_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        type_o,
  output logic              tc_o,
  output logic [NUM_CH-1:0] en_o,
  output logic              update_o
);
  chan_par_t         par [NUM_CH];
  logic [NUM_CH-1:0] en;
  logic              tcstop_q, auto_q;
  logic              copy, step_ok, tc_hit, tc_q, type_ok;

  assign type_ok = (wr_data_i[1:0] != XT_RSVD);
  assign step_ok = xfer_i && en[xfer_ch_i] && !(copy && xfer_ch_i == CH_W'(SRC_CH));
  assign tc_hit  = step_ok && (par[xfer_ch_i].cnt == '0);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit, ld_a, ld_c, ld_t;
    // shadow channel also catches source writes while autoload is on
    if (i == SHD_CH) begin : g_shd
      assign hit = wr_en_i && (wr_ch_i == CH_W'(i) || (auto_q && wr_ch_i == CH_W'(SRC_CH)));
    end else begin : g_std
      assign hit = wr_en_i && (wr_ch_i == CH_W'(i));
    end
    assign ld_a = hit && (wr_field_i == FLD_ADDR);
    assign ld_c = hit && (wr_field_i == FLD_COUNT);
    assign ld_t = hit && (wr_field_i == FLD_TYPE) && type_ok;

    dma_chan_slot u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .ld_addr_i   (ld_a),
      .ld_cnt_i    (ld_c),
      .ld_type_i   (ld_t),
      .wdata_i     (wr_data_i),
      .reload_i    ((i == SRC_CH) && copy),
      .reload_val_i(par[SHD_CH]),
      .step_i      (step_ok && xfer_ch_i == CH_W'(i)),
      .par_o       (par[i])
    );
  end

  dma_mode_ctrl #(.NUM_CH(NUM_CH), .SRC_CH(SRC_CH)) u_mode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_wr_i    (mode_wr_i),
    .mode_en_i    (mode_en_i),
    .mode_tcstop_i(mode_tcstop_i),
    .mode_auto_i  (mode_auto_i),
    .tc_hit_i     (tc_hit),
    .tc_ch_i      (xfer_ch_i),
    .en_o         (en),
    .tcstop_o     (tcstop_q),
    .auto_o       (auto_q)
  );

  dma_autoload_seq u_auto (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(tc_hit && auto_q && xfer_ch_i == CH_W'(SRC_CH)),
    .copy_o (copy),
    .busy_o (update_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tc_q <= 1'b0;
    else         tc_q <= tc_hit;
  end

  assign tc_o   = tc_q;
  assign en_o   = en;
  assign addr_o = par[xfer_ch_i].addr;
  assign type_o = par[xfer_ch_i].kind;
endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk #(
  parameter int NUM_CH = 4,
  parameter int SRC_CH = 2,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_wr_i,
  input logic              xfer_i,
  input logic [CH_W-1:0]   xfer_ch_i,
  input logic              tc_o,
  input logic [NUM_CH-1:0] en_o,
  input logic              update_o,
  input logic              tc_hit,
  input logic              copy,
  input logic              tcstop,
  input logic              auto_on
);
  logic [CH_W-1:0] ch_q;
  logic            src_sel;

  assign src_sel = (xfer_ch_i == CH_W'(SRC_CH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ch_q <= '0;
    else         ch_q <= xfer_ch_i;
  end

  AST_TC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_hit |=> tc_o); // R2
  AST_TC_STOP_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_hit && tcstop && !(auto_on && src_sel) && !mode_wr_i |=> !en_o[ch_q]); // R3
  AST_AUTO_SRC_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_hit && auto_on && src_sel && !mode_wr_i |=> en_o[SRC_CH]); // R3
  AST_TC_EN_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_hit && !tcstop && !mode_wr_i |=> en_o == $past(en_o)); // R4
  AST_NO_TC_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i && !en_o[xfer_ch_i] |=> !tc_o); // R5
  AST_UPD_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_hit && auto_on && src_sel |=> update_o); // R8
  AST_UPD_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy |-> update_o); // R8
  AST_UPD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(update_o) |=> update_o); // R8
  AST_NO_UPD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_o && !auto_on |=> !update_o); // R10
endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(.NUM_CH(NUM_CH), .SRC_CH(SRC_CH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_wr_i(mode_wr_i),
  .xfer_i   (xfer_i),
  .xfer_ch_i(xfer_ch_i),
  .tc_o     (tc_o),
  .en_o     (en_o),
  .update_o (update_o),
  .tc_hit   (tc_hit),
  .copy     (copy),
  .tcstop   (tcstop_q),
  .auto_on  (auto_q)
);

// File: tb/dma_chan_ctrl_test.sv
module dma_chan_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_ch_i = '0;
  logic [1:0]  wr_field_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        mode_wr_i = 1'b0;
  logic [3:0]  mode_en_i = '0;
  logic        mode_tcstop_i = 1'b0;
  logic        mode_auto_i = 1'b0;
  logic        xfer_i = 1'b0;
  logic [1:0]  xfer_ch_i = '0;
  logic [15:0] addr_o;
  logic [1:0]  type_o;
  logic        tc_o;
  logic [3:0]  en_o;
  logic        update_o;

  localparam int S_ADDR = 0, S_TYPE = 1, S_TC = 2, S_EN = 3, S_UPD = 4;

  typedef struct {
    int          due;
    int          sel;
    logic [31:0] val;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_tests = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  dma_chan_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_ch_i(wr_ch_i), .wr_field_i(wr_field_i), .wr_data_i(wr_data_i),
    .mode_wr_i(mode_wr_i), .mode_en_i(mode_en_i), .mode_tcstop_i(mode_tcstop_i),
    .mode_auto_i(mode_auto_i), .xfer_i(xfer_i), .xfer_ch_i(xfer_ch_i),
    .addr_o(addr_o), .type_o(type_o), .tc_o(tc_o), .en_o(en_o), .update_o(update_o)
  );

  function automatic logic [31:0] probe(int sel);
    case (sel)
      S_ADDR:  return {16'd0, addr_o};
      S_TYPE:  return {30'd0, type_o};
      S_TC:    return {31'd0, tc_o};
      S_EN:    return {28'd0, en_o};
      default: return {31'd0, update_o};
    endcase
  endfunction

  // monitor: compare queued expectations once the edge has settled
  initial begin
    forever begin
      @(posedge clk);
      #3;
      cyc++;
      while (q.size() > 0 && q[0].due <= cyc) begin
        exp_t e;
        e = q.pop_front();
        n_tests++;
        if (probe(e.sel) !== e.val) begin
          n_fail++;
          $display("FAIL %s sel=%0d actual=0x%0h expected=0x%0h", e.tag, e.sel, probe(e.sel), e.val);
        end
      end
    end
  end

  task automatic ex(int sel, int val, string tag);
    exp_t e;
    e.due = cyc + 1;
    e.sel = sel;
    e.val = 32'(val);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic quiet();
    wr_en_i = 1'b0;
    mode_wr_i = 1'b0;
    xfer_i = 1'b0;
  endtask

  task automatic look(int ch);
    @(negedge clk);
    quiet();
    xfer_ch_i = 2'(ch);
  endtask

  task automatic wr(int ch, int fld, int data);
    @(negedge clk);
    quiet();
    wr_en_i = 1'b1;
    wr_ch_i = 2'(ch);
    wr_field_i = 2'(fld);
    wr_data_i = 16'(data);
  endtask

  task automatic mode(int en, bit stop, bit auto_on);
    @(negedge clk);
    quiet();
    mode_wr_i = 1'b1;
    mode_en_i = 4'(en);
    mode_tcstop_i = stop;
    mode_auto_i = auto_on;
  endtask

  task automatic xfer(int ch);
    @(negedge clk);
    quiet();
    xfer_i = 1'b1;
    xfer_ch_i = 2'(ch);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    look(0);
    ex(S_EN, 0, "R1 enables"); ex(S_UPD, 0, "R1 update"); ex(S_TC, 0, "R1 tc");
    ex(S_ADDR, 0, "R1 addr"); ex(S_TYPE, 0, "R1 type");

    // R6 field writes, reserved type ignored
    wr(0, 0, 16'h1000); wr(0, 1, 2); wr(0, 2, 2);
    look(0); ex(S_ADDR, 16'h1000, "R6 addr write"); ex(S_TYPE, 2, "R6 type read");
    wr(0, 2, 3);
    look(0); ex(S_TYPE, 2, "R6 reserved type ignored");

    // R5 disabled channel ignores strobe
    xfer(0); ex(S_ADDR, 16'h1000, "R5 disabled addr"); ex(S_TC, 0, "R5 disabled tc");

    // R2 / R3 count down with stop on
    mode(4'b0001, 1'b1, 1'b0);
    xfer(0); ex(S_ADDR, 16'h1001, "R2 addr step"); ex(S_TC, 0, "R2 no tc count 2");
    xfer(0); ex(S_ADDR, 16'h1002, "R2 addr step 2"); ex(S_TC, 0, "R2 no tc count 1");
    xfer(0); ex(S_TC, 1, "R2 tc on zero count"); ex(S_EN, 0, "R3 stop clears enable");
    look(0); ex(S_TC, 0, "R2 tc single cycle"); ex(S_ADDR, 16'h1003, "R2 final addr");
    xfer(0); ex(S_ADDR, 16'h1003, "R5 stopped channel quiet"); ex(S_TC, 0, "R5 stopped no tc");
    mode(4'b0001, 1'b0, 1'b0); ex(S_EN, 1, "R5 re-enable");
    xfer(0); ex(S_ADDR, 16'h1004, "R5 resumed transfer"); ex(S_TC, 0, "R2 wrapped count no tc");

    // R4 stop off keeps enables
    wr(1, 0, 16'h0020); wr(1, 1, 0); wr(1, 2, 1);
    mode(4'b0011, 1'b0, 1'b0);
    xfer(1); ex(S_TC, 1, "R4 tc ch1"); ex(S_EN, 3, "R4 enables kept");
    ex(S_ADDR, 16'h0021, "R2 ch1 addr"); ex(S_TYPE, 1, "R6 type write");

    // R10 autoload off
    wr(2, 0, 16'h0500);
    look(3); ex(S_ADDR, 0, "R10 no mirror"); ex(S_TYPE, 0, "R10 no mirror type");
    mode(4'b0100, 1'b0, 1'b0);
    xfer(2); ex(S_TC, 1, "R10 ch2 tc"); ex(S_UPD, 0, "R10 no update");
    look(2); ex(S_UPD, 0, "R10 no update later");

    // R7 mirror
    mode(4'b1100, 1'b1, 1'b1);
    wr(2, 0, 16'h0200); wr(2, 1, 1); wr(2, 2, 2);
    look(3); ex(S_ADDR, 16'h0200, "R7 addr mirrored"); ex(S_TYPE, 2, "R7 type mirrored");
    wr(3, 0, 16'h0300);
    look(2); ex(S_ADDR, 16'h0200, "R7 ch3 write leaves ch2");

    // R8 update cycle
    xfer(2); ex(S_ADDR, 16'h0201, "R8 ch2 step");
    xfer(2); ex(S_TC, 1, "R8 ch2 tc"); ex(S_UPD, 1, "R8 update raised");
    ex(S_EN, 4'b1100, "R3 ch2 kept in autoload");
    xfer(2); ex(S_UPD, 1, "R8 update held"); ex(S_ADDR, 16'h0300, "R8 reload, strobe ignored");
    ex(S_TYPE, 2, "R8 type reloaded");
    look(2); ex(S_UPD, 0, "R8 update cleared"); ex(S_ADDR, 16'h0300, "R8 addr stays");

    // R9 channel 3 transfers alter reload values
    xfer(3); ex(S_ADDR, 16'h0301, "R9 ch3 step");
    xfer(2); ex(S_ADDR, 16'h0301, "R9 ch2 step");
    xfer(2); ex(S_TC, 1, "R9 ch2 tc"); ex(S_UPD, 1, "R9 update");
    look(2); ex(S_ADDR, 16'h0301, "R9 reload uses advanced ch3");
    look(2); ex(S_UPD, 0, "R9 update cleared");

    // R3 ch3 stops under autoload
    xfer(3); ex(S_TC, 1, "R3 ch3 tc"); ex(S_EN, 4'b0100, "R3 ch3 disabled");

    look(0);
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL queue not drained actual=%0d expected=0", q.size());
    end
    finish_run();
  end
endmodule